// File: doc/BRIEF.md
# Flash Programming Command Sequencer

The sequencer takes 72-bit command words from a command queue and turns each one into transfers on a simple memory-mapped flash bus. That bus has address, write data, byte enables, read data, a request and an acknowledge. Bits 71:64 of a command hold an 8-bit opcode. Bits 63:32 hold a 32-bit upper field and bits 31:0 a 32-bit lower field. Some opcodes carry parameters in their own low bits: the write opcode holds an address-load flag and byte enables, and the program opcode holds a byte count. A 32-bit address register persists from one command to the next.

Commands that return data push 72-bit response words into a response queue. Every response word carries a valid flag, a rolling 3-bit sequence number and the top nibble of the command that produced it. When the response queue reports full, the block stalls in place and loses nothing. A software-driven clear input returns the sequence number to zero. Timed delays are counted in ticks of a slower reference rate, and each tick is a fixed number of core clock cycles.

Top module: `flash_cmd_seq`

## Requirements
- R1: While and after a synchronous reset, `cmd_pop`, `rsp_push` and `bus_req` are low, and the first response pushed carries sequence number 0.
- R2: `cmd_pop` is a single-cycle pulse. It is raised only while `cmd_valid` was high, and exactly one command is consumed per pulse.
- R3: An opcode whose top three bits are 000 or 111, and any opcode not listed in R4 to R8, causes no bus transfer and no response and leaves the address register unchanged.
- R4: Opcode 0010xxxx waits C ticks, where C is bits 7:0 and each tick is TICK_DIV clock cycles. The next command is not popped sooner than C*TICK_DIV cycles after the delay was popped. C=0 adds no wait.
- R5: Opcode 100SEEEE performs one bus write with `bus_be`=EEEE and `bus_wdata` = bits 31:0. The address is bits 63:32 when S=1, in which case the address register is also loaded with them. When S=0 the address is the address register. The address register does not advance.
- R6: Opcode 1011CCCC performs min(C, PROG_MAX) byte writes, taking bytes from the 64-bit payload least significant byte first. Each write has `bus_be`=0001 and the byte in `bus_wdata[7:0]`, with the upper bits zero. The address register advances by one per byte. C=0 performs nothing.
- R7: Opcode 1101xxxx loads the address register from bits 63:32 and then reads N bytes, where N is bits 31:0. Each read takes `bus_rdata[7:0]` and advances the address by one. The bytes are packed least significant first into the 64 data bits of responses, one response per 8 bytes, and the last response is zero-padded. N=0 performs no read and no response.
- R8: Opcode 0110xxxx pushes one response holding the address register in bits 63:32 and bits 31:0 of the command in bits 31:0.
- R9: Every response word has bit 71 = 1, the sequence number in bits 70:68, the command's bits 71:68 in bits 67:64, and data in bits 63:0.
- R10: The sequence number rises by one for each response pushed and wraps from 7 to 0. A one-cycle pulse on `seq_clr` makes the next response carry 0.
- R11: `rsp_push` is never high while `rsp_full` is high. A pending response is held unchanged until it is pushed, and no further command is popped meanwhile.
- R12: Once `bus_req` rises, it and the address, data, byte enables and direction stay stable until the cycle in which `bus_ack` is sampled high. `bus_req` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command queue holds a word |
| cmd_data | input | 72 | Command word at the head of the queue |
| cmd_pop | output | 1 | Removes the head command word |
| rsp_full | input | 1 | Response queue cannot accept a word |
| rsp_push | output | 1 | Writes `rsp_data` into the response queue |
| rsp_data | output | 72 | Tagged response word |
| seq_clr | input | 1 | Clears the response sequence number |
| bus_req | output | 1 | Flash bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_be | output | 4 | Byte enables |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer complete |

## Verification
The assertions check the following on every cycle:
- the single-cycle pop that follows a valid command;
- that no push happens into a full response queue, and that the pending word is held during a stall;
- the valid flag of each response and the step-by-one or restart-at-zero sequence rule;
- the request and acknowledge stability rules of the flash bus.

The contents of the traffic can only be shown by the bench's scenarios. These cover the exact addresses, enables and data of writes, byte order within packed responses, zero padding, the program count limit, address advance across commands, the length of delays, and the absence of any effect from no-op and zero-count commands.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_DELAY,
    ST_BUS,
    ST_RSP
  } seq_state_t;

  typedef enum logic [2:0] {
    K_NONE,
    K_DELAY,
    K_WRITE,
    K_PROG,
    K_READ,
    K_TOKEN
  } cmd_kind_t;

  // Classify the opcode byte; fixed and variable fields share the byte.
  function automatic cmd_kind_t decode_op(input logic [7:0] op);
    cmd_kind_t k;
    casez (op)
      8'b000?_????: k = K_NONE;
      8'b111?_????: k = K_NONE;
      8'b0010_????: k = K_DELAY;
      8'b0110_????: k = K_TOKEN;
      8'b100?_????: k = K_WRITE;
      8'b1011_????: k = K_PROG;
      8'b1101_????: k = K_READ;
      default:      k = K_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/flash_tick_timer.sv
module flash_tick_timer #(
  parameter int TICK_DIV = 10,
  parameter int TICK_W   = 8,
  localparam int PRE_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TICK_W-1:0] ticks,
  output logic              busy
);

  logic [TICK_W-1:0] remain;
  logic [PRE_W-1:0]  pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      pre    <= '0;
    end else if (load) begin
      remain <= ticks;
      pre    <= '0;
    end else if (remain != '0) begin
      if (pre == PRE_W'(TICK_DIV - 1)) begin
        pre    <= '0;
        remain <= remain - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/flash_bus_port.sv
module flash_bus_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              done,
  output logic [DATA_W-1:0] rdata_q,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_be    <= '0;
      done      <= 1'b0;
      rdata_q   <= '0;
    end else begin
      done <= 1'b0;
      if (bus_req && bus_ack) begin
        bus_req <= 1'b0;
        done    <= 1'b1;
        rdata_q <= bus_rdata;
      end else if (start && !bus_req) begin
        bus_req   <= 1'b1;
        bus_we    <= we_i;
        bus_addr  <= addr_i;
        bus_wdata <= wdata_i;
        bus_be    <= be_i;
      end
    end
  end

endmodule

// File: rtl/flash_rsp_tagger.sv
module flash_rsp_tagger #(
  parameter int SEQ_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [SEQ_W-1:0] seq
);

  always_ff @(posedge clk) begin
    if (rst || clr) seq <= '0;
    else if (adv)   seq <= seq + 1'b1;
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int CMD_W    = 72,
  parameter int BUS_DW   = 32,
  parameter int BE_W     = 4,
  parameter int SEQ_W    = 3,
  parameter int TICK_DIV = 10,
  parameter int PROG_MAX = 8,
  localparam int FLD_W   = (CMD_W - 8) / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              cmd_pop,
  input  logic              rsp_full,
  output logic              rsp_push,
  output logic [CMD_W-1:0]  rsp_data,
  input  logic              seq_clr,
  output logic              bus_req,
  output logic              bus_we,
  output logic [FLD_W-1:0]  bus_addr,
  output logic [BUS_DW-1:0] bus_wdata,
  output logic [BE_W-1:0]   bus_be,
  input  logic [BUS_DW-1:0] bus_rdata,
  input  logic              bus_ack
);

  localparam int PAY_W     = CMD_W - 8;
  localparam int RSP_BYTES = PAY_W / 8;
  localparam int PK_W      = $clog2(RSP_BYTES);
  localparam int CNT_W     = 4;

  seq_state_t        st;
  cmd_kind_t         kind;
  logic [CMD_W-1:0]  cmd_r;
  logic [7:0]        op;
  logic [FLD_W-1:0]  f_hi, f_lo;
  logic [FLD_W-1:0]  addr_r, remain, prog_n;
  logic [PAY_W-1:0]  pdata, pk_data, pk_next, rsp_word;
  logic [PK_W-1:0]   pk_cnt;
  logic [CNT_W-1:0]  op_cnt;
  logic [SEQ_W-1:0]  seq;
  logic              rsp_wait;

  logic              bp_start, bp_we, bp_done;
  logic [FLD_W-1:0]  bp_addr;
  logic [BUS_DW-1:0] bp_wdata, bp_rdata;
  logic [BE_W-1:0]   bp_be;
  logic              tm_load, tm_busy;

  assign op     = cmd_r[CMD_W-1 -: 8];
  assign f_hi   = cmd_r[PAY_W-1 -: FLD_W];
  assign f_lo   = cmd_r[FLD_W-1:0];
  assign kind   = decode_op(op);
  assign op_cnt = op[CNT_W-1:0];
  assign prog_n = (int'(op_cnt) > PROG_MAX) ? FLD_W'(PROG_MAX) : FLD_W'(op_cnt);

  // Merge the byte just read into the pack register.
  assign pk_next = pk_data | (PAY_W'(bp_rdata[7:0]) << {pk_cnt, 3'b000});

  assign tm_load  = (st == ST_EXEC) && (kind == K_DELAY) && (f_lo[7:0] != 8'd0);
  assign rsp_wait = (st == ST_RSP);
  assign rsp_push = rsp_wait && !rsp_full;
  assign rsp_data = {1'b1, seq, op[7:4], rsp_word};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cmd_r    <= '0;
      cmd_pop  <= 1'b0;
      addr_r   <= '0;
      remain   <= '0;
      pdata    <= '0;
      pk_data  <= '0;
      pk_cnt   <= '0;
      rsp_word <= '0;
      bp_start <= 1'b0;
      bp_we    <= 1'b0;
      bp_addr  <= '0;
      bp_wdata <= '0;
      bp_be    <= '0;
    end else begin
      cmd_pop  <= 1'b0;
      bp_start <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            cmd_r   <= cmd_data;
            cmd_pop <= 1'b1;
            st      <= ST_EXEC;
          end
        end

        ST_EXEC: begin
          case (kind)
            K_DELAY: st <= tm_load ? ST_DELAY : ST_IDLE;
            K_WRITE: begin
              if (op[4]) addr_r <= f_hi;
              bp_start <= 1'b1;
              bp_we    <= 1'b1;
              bp_addr  <= op[4] ? f_hi : addr_r;
              bp_wdata <= BUS_DW'(f_lo);
              bp_be    <= op[BE_W-1:0];
              st       <= ST_BUS;
            end
            K_PROG: begin
              if (prog_n == '0) begin
                st <= ST_IDLE;
              end else begin
                remain   <= prog_n;
                pdata    <= cmd_r[PAY_W-1:0];
                bp_start <= 1'b1;
                bp_we    <= 1'b1;
                bp_addr  <= addr_r;
                bp_wdata <= BUS_DW'(cmd_r[7:0]);
                bp_be    <= BE_W'(1);
                st       <= ST_BUS;
              end
            end
            K_READ: begin
              addr_r  <= f_hi;
              pk_data <= '0;
              pk_cnt  <= '0;
              if (f_lo == '0) begin
                st <= ST_IDLE;
              end else begin
                remain   <= f_lo;
                bp_start <= 1'b1;
                bp_we    <= 1'b0;
                bp_addr  <= f_hi;
                bp_wdata <= '0;
                bp_be    <= '1;
                st       <= ST_BUS;
              end
            end
            K_TOKEN: begin
              rsp_word <= {addr_r, f_lo};
              st       <= ST_RSP;
            end
            default: st <= ST_IDLE;
          endcase
        end

        ST_DELAY: begin
          if (!tm_busy) st <= ST_IDLE;
        end

        ST_BUS: begin
          if (bp_done) begin
            case (kind)
              K_PROG: begin
                addr_r <= addr_r + 1'b1;
                remain <= remain - 1'b1;
                pdata  <= pdata >> 8;
                if (remain == FLD_W'(1)) begin
                  st <= ST_IDLE;
                end else begin
                  bp_start <= 1'b1;
                  bp_we    <= 1'b1;
                  bp_addr  <= addr_r + 1'b1;
                  bp_wdata <= BUS_DW'(pdata[15:8]);
                  bp_be    <= BE_W'(1);
                end
              end
              K_READ: begin
                addr_r <= addr_r + 1'b1;
                remain <= remain - 1'b1;
                if ((remain == FLD_W'(1)) || (pk_cnt == PK_W'(RSP_BYTES - 1))) begin
                  rsp_word <= pk_next;
                  pk_data  <= '0;
                  pk_cnt   <= '0;
                  st       <= ST_RSP;
                end else begin
                  pk_data  <= pk_next;
                  pk_cnt   <= pk_cnt + 1'b1;
                  bp_start <= 1'b1;
                  bp_we    <= 1'b0;
                  bp_addr  <= addr_r + 1'b1;
                  bp_wdata <= '0;
                  bp_be    <= '1;
                end
              end
              default: st <= ST_IDLE;
            endcase
          end
        end

        ST_RSP: begin
          if (!rsp_full) begin
            if ((kind == K_READ) && (remain != '0)) begin
              bp_start <= 1'b1;
              bp_we    <= 1'b0;
              bp_addr  <= addr_r;
              bp_wdata <= '0;
              bp_be    <= '1;
              st       <= ST_BUS;
            end else begin
              st <= ST_IDLE;
            end
          end
        end

        default: st <= ST_IDLE;
      endcase
    end
  end

  flash_bus_port #(
    .ADDR_W(FLD_W),
    .DATA_W(BUS_DW),
    .BE_W  (BE_W)
  ) bus_port_i (
    .clk      (clk),
    .rst      (rst),
    .start    (bp_start),
    .we_i     (bp_we),
    .addr_i   (bp_addr),
    .wdata_i  (bp_wdata),
    .be_i     (bp_be),
    .done     (bp_done),
    .rdata_q  (bp_rdata),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_be   (bus_be),
    .bus_rdata(bus_rdata),
    .bus_ack  (bus_ack)
  );

  flash_tick_timer #(
    .TICK_DIV(TICK_DIV),
    .TICK_W  (8)
  ) timer_i (
    .clk  (clk),
    .rst  (rst),
    .load (tm_load),
    .ticks(f_lo[7:0]),
    .busy (tm_busy)
  );

  flash_rsp_tagger #(
    .SEQ_W(SEQ_W)
  ) tagger_i (
    .clk(clk),
    .rst(rst),
    .clr(seq_clr),
    .adv(rsp_push),
    .seq(seq)
  );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int CMD_W  = 72,
  parameter int BUS_DW = 32,
  parameter int BE_W   = 4,
  parameter int SEQ_W  = 3,
  parameter int FLD_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_pop,
  input logic              rsp_full,
  input logic              rsp_push,
  input logic [CMD_W-1:0]  rsp_data,
  input logic              seq_clr,
  input logic              rsp_wait,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_we,
  input logic [FLD_W-1:0]  bus_addr,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic [BE_W-1:0]   bus_be
);

  logic [SEQ_W-1:0] last_seq;
  logic             have_last;
  logic [SEQ_W-1:0] cur_seq;

  assign cur_seq = rsp_data[CMD_W-2 -: SEQ_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      have_last <= 1'b0;
      last_seq  <= '0;
    end else if (rsp_push) begin
      last_seq  <= cur_seq;
      have_last <= !seq_clr;
    end else if (seq_clr) begin
      have_last <= 1'b0;
    end
  end

  // R2
  pop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_pop |=> !cmd_pop);

  // R2
  pop_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_pop) |-> $past(cmd_valid));

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_push |-> !rsp_full);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_wait && rsp_full && !seq_clr) |=> (rsp_wait && $stable(rsp_data)));

  // R9
  rsp_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_push |-> rsp_data[CMD_W-1]);

  // R10
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_push && have_last) |-> (cur_seq == SEQ_W'(last_seq + 1'b1)));

  // R1
  seq_start_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_push && !have_last) |-> (cur_seq == '0));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata)
                               && $stable(bus_be) && $stable(bus_we)));

  // R12
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack) |=> !bus_req);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .CMD_W (CMD_W),
  .BUS_DW(BUS_DW),
  .BE_W  (BE_W),
  .SEQ_W (SEQ_W),
  .FLD_W (FLD_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_pop  (cmd_pop),
  .rsp_full (rsp_full),
  .rsp_push (rsp_push),
  .rsp_data (rsp_data),
  .seq_clr  (seq_clr),
  .rsp_wait (rsp_wait),
  .bus_req  (bus_req),
  .bus_ack  (bus_ack),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_be   (bus_be)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

  localparam int DIV = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [71:0] cmd_data = '0;
  logic        cmd_pop;
  logic        rsp_full = 1'b0;
  logic        rsp_push;
  logic [71:0] rsp_data;
  logic        seq_clr = 1'b0;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_pop(cmd_pop), .rsp_full(rsp_full), .rsp_push(rsp_push),
    .rsp_data(rsp_data), .seq_clr(seq_clr), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lat = 0;

  logic [71:0] cq[$];
  logic [71:0] rq[$];
  logic [71:0] ersp[$];
  logic [68:0] blog[$];
  logic [68:0] ebus[$];
  int          pop_cyc[$];
  logic [7:0]  mem[256];
  logic [7:0]  m_mem[256];
  logic [31:0] m_addr = '0;
  logic [2:0]  m_seq = '0;

  task automatic chk(input bit ok, input string tag, input logic [71:0] act,
                     input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Command queue and flash bus responder, driven just after each edge.
  always begin
    @(posedge clk);
    #1;
    cyc++;
    if (cmd_pop && cq.size() > 0) begin
      void'(cq.pop_front());
      pop_cyc.push_back(cyc);
    end
    cmd_valid = (cq.size() > 0);
    cmd_data  = (cq.size() > 0) ? cq[0] : '0;
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (lat == 0) begin
        bus_ack = 1'b1;
        blog.push_back({bus_we, bus_addr, bus_we ? bus_be : 4'h0,
                        bus_we ? bus_wdata : 32'h0});
        if (bus_we && bus_be[0]) mem[bus_addr[7:0]] = bus_wdata[7:0];
        bus_rdata = {24'($urandom), mem[bus_addr[7:0]]};
        lat = $urandom % 3;
      end else begin
        lat--;
      end
    end
  end

  always @(negedge clk) if (!rst && rsp_push) rq.push_back(rsp_data);

  function automatic int kind_of(input logic [7:0] op);
    if (op[7:5] == 3'b000 || op[7:5] == 3'b111) return 0;
    if (op[7:4] == 4'h2) return 1;
    if (op[7:5] == 3'b100) return 2;
    if (op[7:4] == 4'hB) return 3;
    if (op[7:4] == 4'hD) return 4;
    if (op[7:4] == 4'h6) return 5;
    return 0;
  endfunction

  task automatic exp_rsp(input logic [3:0] nib, input logic [63:0] d);
    ersp.push_back({1'b1, m_seq, nib, d});
    m_seq = m_seq + 3'd1;
  endtask

  // Queue a command and predict its effects from the requirements.
  task automatic send(input logic [71:0] c);
    logic [7:0]  op;
    logic [31:0] hi, lo;
    logic [63:0] w;
    int n, k;
    op = c[71:64];
    hi = c[63:32];
    lo = c[31:0];
    cq.push_back(c);
    case (kind_of(op))
      2: begin
        if (op[4]) m_addr = hi;
        ebus.push_back({1'b1, m_addr, op[3:0], lo});
        if (op[0]) m_mem[m_addr[7:0]] = lo[7:0];
      end
      3: begin
        n = (op[3:0] > 8) ? 8 : int'(op[3:0]);
        for (int i = 0; i < n; i++) begin
          ebus.push_back({1'b1, m_addr, 4'h1, 24'h0, c[8*i +: 8]});
          m_mem[m_addr[7:0]] = c[8*i +: 8];
          m_addr = m_addr + 1;
        end
      end
      4: begin
        m_addr = hi;
        w = '0;
        k = 0;
        for (int i = 0; i < int'(lo); i++) begin
          ebus.push_back({1'b0, m_addr, 4'h0, 32'h0});
          w[8*k +: 8] = m_mem[m_addr[7:0]];
          m_addr = m_addr + 1;
          k++;
          if (k == 8 || i == int'(lo) - 1) begin
            exp_rsp(op[7:4], w);
            w = '0;
            k = 0;
          end
        end
      end
      5: exp_rsp(op[7:4], {m_addr, lo});
      default: ;
    endcase
  endtask

  // Wait for the traffic to settle, then compare everything observed.
  task automatic drain(input string tag);
    int guard = 0;
    while ((cq.size() > 0 || rq.size() < ersp.size() || blog.size() < ebus.size())
           && guard < 20000) begin
      @(posedge clk);
      guard++;
    end
    repeat (20) @(posedge clk);
    chk(rq.size() == ersp.size(), {tag, " response count"}, 72'(rq.size()), 72'(ersp.size()));
    chk(blog.size() == ebus.size(), {tag, " bus count"}, 72'(blog.size()), 72'(ebus.size()));
    for (int i = 0; i < ersp.size() && i < rq.size(); i++)
      chk(rq[i] === ersp[i], {tag, " response word"}, rq[i], ersp[i]);
    for (int i = 0; i < ebus.size() && i < blog.size(); i++)
      chk(blog[i] === ebus[i], {tag, " bus transfer"}, 72'(blog[i]), 72'(ebus[i]));
    rq.delete();
    ersp.delete();
    blog.delete();
    ebus.delete();
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #750000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 8'(i * 7 + 3);
      m_mem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(posedge clk);
    #1;
    // R1: outputs idle in reset
    chk(!cmd_pop && !rsp_push && !bus_req, "R1 reset outputs", 72'({cmd_pop, rsp_push, bus_req}), 72'(0));
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk(!cmd_pop && !rsp_push && !bus_req, "R1 after reset", 72'({cmd_pop, rsp_push, bus_req}), 72'(0));

    // R8 R9 R1: token response with sequence 0, address register at reset value
    send({8'h60, 32'h0, 32'hCAFE_0001});
    drain("R8");

    // R5: write with address load, then without
    send({8'h91, 32'h0000_0040, 32'h1234_56A5});
    send({8'h8C, 32'hFFFF_FFFF, 32'h0BAD_F00D});
    send({8'h60, 32'h0, 32'h0000_0005});
    drain("R5");

    // R6: program 3 bytes, LSB first; then count above limit clamps
    send({8'hD0, 32'h0000_0080, 32'h0});
    send({8'hB3, 64'h1111_2222_0033_4455});
    send({8'hBF, 64'h8877_6655_4433_2211});
    send({8'h60, 32'h0, 32'h0000_0006});
    drain("R6");

    // R7: read 3 bytes (padding), read 10 bytes (two responses), read 0
    send({8'hD0, 32'h0000_0081, 32'd3});
    send({8'hD7, 32'h0000_0010, 32'd10});
    send({8'hD0, 32'h0000_00A0, 32'd0});
    send({8'h60, 32'h0, 32'h0000_0007});
    drain("R7");

    // R3: no-ops, undefined opcodes and zero-count program leave all untouched
    send({8'h1F, 64'hFFFF_FFFF_FFFF_FFFF});
    send({8'hE3, 64'h0123_4567_89AB_CDEF});
    send({8'h35, 64'h0000_0010_0000_0004});
    send({8'hA0, 64'h0000_0011_0000_0004});
    send({8'hB0, 64'h0000_0012_0000_0004});
    send({8'h60, 32'h0, 32'h0000_0008});
    drain("R3");

    // R4: delay of 4 ticks versus zero ticks
    pop_cyc.delete();
    send({8'h20, 32'h0, 32'd4});
    send({8'h00, 64'h0});
    send({8'h20, 32'h0, 32'd0});
    send({8'h00, 64'h0});
    drain("R4");
    if (pop_cyc.size() == 4) begin
      d = pop_cyc[1] - pop_cyc[0];
      chk(d >= 4 * DIV && d <= 4 * DIV + 4, "R4 delay length", 72'(d), 72'(4 * DIV));
      d = pop_cyc[3] - pop_cyc[2];
      chk(d <= 4, "R4 zero delay", 72'(d), 72'(2));
    end else begin
      chk(1'b0, "R4 pop count", 72'(pop_cyc.size()), 72'(4));
    end

    // R11: full response queue stalls the sequencer
    @(posedge clk);
    #1;
    rsp_full = 1'b1;
    send({8'hD0, 32'h0000_0020, 32'd3});
    send({8'h60, 32'h0, 32'h0000_0009});
    repeat (80) @(posedge clk);
    #1;
    chk(rq.size() == 0, "R11 no push while full", 72'(rq.size()), 72'(0));
    chk(cq.size() == 1, "R11 next command held", 72'(cq.size()), 72'(1));
    rsp_full = 1'b0;
    drain("R11");

    // R10: clear pulse restarts the sequence
    @(posedge clk);
    #1;
    seq_clr = 1'b1;
    @(posedge clk);
    #1;
    seq_clr = 1'b0;
    m_seq = '0;
    send({8'h60, 32'h0, 32'h0000_000A});
    drain("R10 clear");

    // R2 R10 R12: constrained random mix, sequence wraps several times
    for (int i = 0; i < 80; i++) begin
      int sel;
      logic [31:0] a;
      sel = $urandom % 6;
      a = 32'($urandom % 200);
      case (sel)
        0: send({8'h00 | 8'($urandom % 32), 64'($urandom)});
        1: send({4'h8, 1'($urandom), 3'($urandom), a, 32'($urandom)});
        2: send({4'hB, 4'($urandom % 10), 32'($urandom), 32'($urandom)});
        3: send({8'hD0, a, 32'($urandom % 12)});
        4: send({8'h60, 32'h0, 32'($urandom)});
        default: send({8'h20, 32'h0, 32'($urandom % 3)});
      endcase
    end
    drain("R2 R10 random");

    finish_up();
  end

endmodule